// File: doc/BRIEF.md
# Three-Phase Imbalance Detector

The block takes three signed phase samples, adds them into a zero-sequence sum and averages that sum with a first-order exponential low-pass filter. The filter moves only on cycles where the sample strobe is high. Its time constant is set by a 4-bit shift, so slow rotation can be given a long averaging window. In a balanced three-phase system the sum stays near zero. A sustained offset, such as a phase that has opened, drives the averaged sum away from zero and raises a single registered imbalance flag.

The flag rises when the magnitude of the averaged sum is larger than three times a threshold word. A threshold of zero selects a built-in value equal to one quarter of the nominal peak phase level. A mode input states whether the phase inputs carry a real three-phase set. When it does not, the flag is held low, because the sum carries no meaning for two orthogonal signals.

Top module: `imb_detect`

## Requirements
- R1: A synchronous active-high reset clears the filter accumulator and the flag. The flag reads 0 in the first cycle after reset is released.
- R2: The sum S is ph_a + ph_b + ph_c, computed at full width. On a cycle with smp_vld = 1 the accumulator A becomes A + ((S·16 − A) >>> k), with arithmetic (floor) shifting, where k = shift. The accumulator has 4 fraction bits, and the filtered value is A >>> 4.
- R3: On a cycle with smp_vld = 0 the accumulator keeps its value, and the phase inputs have no effect on it.
- R4: After each clock edge the flag is 1 exactly when, in the cycle before, three_ph was 1 and |A >>> 4| > 3·T. The comparison is strict, so equality gives 0.
- R5: T equals the thr input, except that thr = 0 selects T = 4096. This is one quarter of the nominal peak level 16384.
- R6: When three_ph = 0, the flag is 0 after the next clock edge, whatever the filtered value.
- R7: With k = 0, one valid sample sets the filtered value equal to S.
- R8: The flag is registered. A change of thr, three_ph or the accumulator shows on the flag one clock later and not earlier.
- R9: Full-scale phases do not overflow. Three samples of −32768 give a magnitude of 98304, and three samples of 32767 give 98301.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_a | input | 16 | Phase A sample, signed |
| ph_b | input | 16 | Phase B sample, signed |
| ph_c | input | 16 | Phase C sample, signed |
| smp_vld | input | 1 | Sample strobe; the filter updates when high |
| thr | input | 15 | Threshold, unsigned; 0 selects the built-in default |
| shift | input | 4 | Filter shift k (0 = no averaging, 15 = slowest) |
| three_ph | input | 1 | 1 = three-phase input mode, 0 = two-phase (flag forced low) |
| imb_flag | output | 1 | Registered imbalance flag |

## Verification
Two things can happen at the same clock edge: a valid sample updates the accumulator, and the comparator registers a flag from that accumulator. The flag must use the value from before the update. Random stimulus sends strobes on back-to-back cycles while thr moves every cycle. The bench model computes the flag from its accumulator before it applies the update, so a design that compares the new value fails within a few cycles. A second overlap is a drop of three_ph in the same cycle that a strong imbalance would set the flag. This is provoked directly, and the expected result is a low flag.

// File: rtl/imb_pkg.sv
package imb_pkg;

    // Base widths and constants
    localparam int PH_W     = 16;          // phase sample width (signed)
    localparam int SH_W     = 4;           // filter shift width
    localparam int FRAC_W   = 4;           // accumulator fraction bits
    localparam int NOM_PEAK = 16384;       // nominal peak phase level

    // Derived widths
    localparam int SUM_W  = PH_W + 2;                  // sum of three phases
    localparam int ACC_W  = SUM_W + FRAC_W;            // accumulator
    localparam int DIFF_W = ACC_W + 1;                 // filter error term
    localparam int MAG_W  = SUM_W;                     // |filtered sum|
    localparam int THR_W  = PH_W - 1;                  // threshold word
    localparam int LIM_W  = THR_W + 2;                 // 3 * threshold
    localparam int CMP_W  = (MAG_W > LIM_W) ? MAG_W : LIM_W;
    localparam int DEF_THR = NOM_PEAK / 4;

    typedef logic signed [PH_W-1:0]   phase_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [DIFF_W-1:0] diff_t;
    typedef logic        [MAG_W-1:0]  mag_t;
    typedef logic        [THR_W-1:0]  thr_t;
    typedef logic        [LIM_W-1:0]  lim_t;
    typedef logic        [CMP_W-1:0]  cmp_t;

    typedef enum logic {
        MODE_2PH = 1'b0,
        MODE_3PH = 1'b1
    } mode_e;

    // Filter update request carried from the top to the filter
    typedef struct packed {
        logic            vld;
        logic [SH_W-1:0] shift;
    } upd_t;

    // Zero-sequence sum at full width
    function automatic sum_t zero_seq(input phase_t a, input phase_t b, input phase_t c);
        return sum_t'(a) + sum_t'(b) + sum_t'(c);
    endfunction

    // Magnitude of a signed sum, computed one bit wider to avoid wrap
    function automatic mag_t magnitude(input sum_t s);
        logic signed [SUM_W:0] w;
        w = {s[SUM_W-1], s};
        if (w < 0)
            w = -w;
        return w[MAG_W-1:0];
    endfunction

    // Three times the threshold
    function automatic lim_t triple(input thr_t t);
        return {2'b00, t} + {1'b0, t, 1'b0};
    endfunction

endpackage

// File: rtl/imb_zsum.sv
module imb_zsum
    import imb_pkg::*;
(
    input  phase_t ph_a,
    input  phase_t ph_b,
    input  phase_t ph_c,
    output sum_t   sum
);

    always_comb begin
        sum = zero_seq(ph_a, ph_b, ph_c);
    end

endmodule

// File: rtl/imb_filter.sv
module imb_filter
    import imb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  upd_t upd,
    input  sum_t sum,
    output acc_t acc,
    output sum_t filt
);

    acc_t  acc_q;
    acc_t  x_ext;
    diff_t err;
    diff_t step;
    acc_t  acc_d;

    always_comb begin
        x_ext = {sum, {FRAC_W{1'b0}}};
        err   = diff_t'(x_ext) - diff_t'(acc_q);
        step  = err >>> upd.shift;
        acc_d = acc_q + acc_t'(step);
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (upd.vld)
            acc_q <= acc_d;
    end

    assign acc  = acc_q;
    assign filt = sum_t'(acc_q >>> FRAC_W);

endmodule

// File: rtl/imb_thresh.sv
module imb_thresh
    import imb_pkg::*;
#(
    parameter bit ZERO_IS_DEFAULT = 1'b1
)(
    input  thr_t thr,
    output lim_t lim
);

    generate
        if (ZERO_IS_DEFAULT) begin : g_def
            thr_t t_eff;
            always_comb begin
                t_eff = (thr == '0) ? thr_t'(DEF_THR) : thr;
                lim   = triple(t_eff);
            end
        end else begin : g_raw
            always_comb begin
                lim = triple(thr);
            end
        end
    endgenerate

endmodule

// File: rtl/imb_cmp.sv
module imb_cmp
    import imb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  sum_t  filt,
    input  lim_t  lim,
    output mag_t  mag,
    output logic  flag
);

    logic over;
    logic flag_q;

    always_comb begin
        mag  = magnitude(filt);
        over = cmp_t'(mag) > cmp_t'(lim);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else
            flag_q <= (mode == MODE_3PH) && over;
    end

    assign flag = flag_q;

endmodule

// File: rtl/imb_detect.sv
module imb_detect
    import imb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [15:0]      ph_a,
    input  logic signed [15:0]      ph_b,
    input  logic signed [15:0]      ph_c,
    input  logic                    smp_vld,
    input  logic        [14:0]      thr,
    input  logic        [3:0]       shift,
    input  logic                    three_ph,
    output logic                    imb_flag
);

    sum_t  sum;
    acc_t  acc;
    sum_t  filt;
    lim_t  lim;
    mag_t  mag;
    upd_t  upd;
    mode_e mode;

    assign upd.vld   = smp_vld;
    assign upd.shift = shift;
    assign mode      = three_ph ? MODE_3PH : MODE_2PH;

    imb_zsum u_zsum (
        .ph_a (ph_a),
        .ph_b (ph_b),
        .ph_c (ph_c),
        .sum  (sum)
    );

    imb_filter u_filter (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd),
        .sum  (sum),
        .acc  (acc),
        .filt (filt)
    );

    imb_thresh #(.ZERO_IS_DEFAULT(1'b1)) u_thresh (
        .thr (thr),
        .lim (lim)
    );

    imb_cmp u_cmp (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .filt (filt),
        .lim  (lim),
        .mag  (mag),
        .flag (imb_flag)
    );

endmodule

// File: rtl/imb_detect_chk.sv
module imb_detect_chk
    import imb_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic smp_vld,
    input logic [3:0] shift,
    input logic three_ph,
    input logic imb_flag,
    input sum_t sum,
    input acc_t acc,
    input mag_t mag,
    input lim_t lim
);

    acc_t x_ext;
    assign x_ext = {sum, {FRAC_W{1'b0}}};

    // R1
    reset_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !imb_flag);

    // R3
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(acc));

    // R2
    filter_moves_up_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && (x_ext >= acc)) |=> ((acc >= $past(acc)) && (acc <= $past(x_ext))));

    // R2
    filter_moves_down_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && (x_ext < acc)) |=> ((acc <= $past(acc)) && (acc >= $past(x_ext))));

    // R7
    passthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && (shift == 4'd0)) |=> (acc == $past(x_ext)));

    // R6
    two_phase_low_chk: assert property (@(posedge clk) disable iff (rst)
        !three_ph |=> !imb_flag);

    // R4
    flag_needs_excess_chk: assert property (@(posedge clk) disable iff (rst)
        imb_flag |-> (cmp_t'($past(mag)) > cmp_t'($past(lim))));

    // R8
    flag_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (three_ph && (cmp_t'(mag) > cmp_t'(lim))) |=> imb_flag);

endmodule

bind imb_detect imb_detect_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .shift    (shift),
    .three_ph (three_ph),
    .imb_flag (imb_flag),
    .sum      (sum),
    .acc      (acc),
    .mag      (mag),
    .lim      (lim)
);

// File: tb/imb_detect_tb.sv
`timescale 1ns/1ps
module imb_detect_tb;

    localparam int FRAC  = 4;
    localparam int DEF_T = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [15:0] ph_a = '0, ph_b = '0, ph_c = '0;
    logic smp_vld = 1'b0;
    logic [14:0] thr = '0;
    logic [3:0] shift = '0;
    logic three_ph = 1'b0;
    logic imb_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint m_acc = 0;
    bit m_flag = 1'b0;

    always #4 clk = ~clk;

    imb_detect u_dut (
        .clk(clk), .rst(rst), .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
        .smp_vld(smp_vld), .thr(thr), .shift(shift), .three_ph(three_ph),
        .imb_flag(imb_flag)
    );

    function automatic bit model_flag(bit mode, int t, longint acc);
        longint f, mag, lim;
        f   = acc >>> FRAC;
        mag = (f < 0) ? -f : f;
        lim = 3 * ((t == 0) ? DEF_T : t);
        return mode && (mag > lim);
    endfunction

    function automatic longint model_acc(longint acc, longint s, int k);
        longint x;
        x = s * (1 << FRAC);
        return acc + ((x - acc) >>> k);
    endfunction

    task automatic check_flag(string tag);
        checks++;
        if (imb_flag !== m_flag) begin
            errors++;
            $display("FAIL %s flag=%0b expected=%0b", tag, imb_flag, m_flag);
        end
    endtask

    // One cycle: check the previous result, drive new inputs, advance the model
    task automatic cyc(int a, int b, int c, bit v, int t, int k, bit mode, string tag);
        @(negedge clk);
        check_flag(tag);
        ph_a = 16'(a); ph_b = 16'(b); ph_c = 16'(c);
        smp_vld = v; thr = 15'(t); shift = 4'(k); three_ph = mode;
        m_flag = model_flag(mode, t, m_acc);
        if (v)
            m_acc = model_acc(m_acc, longint'(ph_a) + longint'(ph_b) + longint'(ph_c), k);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_acc = 0;
        m_flag = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7301));
        do_reset();
        // R1: flag low right after reset
        cyc(0, 0, 0, 0, 1, 0, 1, "R1");
        cyc(0, 0, 0, 0, 1, 0, 1, "R1");

        // R7 / R5: pass-through, default threshold edge (limit 12288)
        cyc(12289, 0, 0, 1, 0, 0, 1, "R7");
        cyc(0, 0, 0, 0, 0, 0, 1, "R5");
        cyc(0, 0, 0, 0, 0, 0, 1, "R5");
        cyc(12288, 0, 0, 1, 0, 0, 1, "R4");
        cyc(0, 0, 0, 0, 0, 0, 1, "R4");
        cyc(0, 0, 0, 0, 0, 0, 1, "R4");
        cyc(-12289, 0, 0, 1, 4096, 0, 1, "R4");
        cyc(0, 0, 0, 0, 4096, 0, 1, "R4");
        cyc(0, 0, 0, 0, 4095, 0, 1, "R5");
        cyc(0, 0, 0, 0, 4095, 0, 1, "R5");

        // R6: strong imbalance while two-phase mode, and a drop in the same cycle
        cyc(30000, 30000, 30000, 1, 1, 0, 0, "R6");
        cyc(0, 0, 0, 0, 1, 0, 0, "R6");
        cyc(0, 0, 0, 0, 1, 0, 1, "R6");
        cyc(0, 0, 0, 0, 1, 0, 0, "R6");
        cyc(0, 0, 0, 0, 1, 0, 0, "R6");

        // R9: full-scale extremes
        cyc(-32768, -32768, -32768, 1, 32767, 0, 1, "R9");
        cyc(0, 0, 0, 0, 32767, 0, 1, "R9");
        cyc(0, 0, 0, 0, 32767, 0, 1, "R9");
        cyc(0, 0, 0, 0, 32767, 0, 1, "R9");
        cyc(32767, 32767, 32767, 1, 32767, 0, 1, "R9");
        cyc(0, 0, 0, 0, 32767, 0, 1, "R9");
        cyc(0, 0, 0, 0, 32767, 0, 1, "R9");

        // R8: threshold toggles each cycle, flag follows one cycle later
        cyc(20000, 0, 0, 1, 1, 0, 1, "R8");
        for (int i = 0; i < 40; i++)
            cyc(0, 0, 0, 0, (i % 2 == 0) ? 32767 : 6000, 0, 1, "R8");

        // R1: reset in the middle of an asserted flag
        do_reset();
        for (int i = 0; i < 6; i++)
            cyc(0, 0, 0, 0, 1, 0, 1, "R1");

        // R2: slow filter, constant offset
        for (int i = 0; i < 400; i++)
            cyc(8000, 2000, 1000, 1, 2000, 15, 1, "R2");
        for (int i = 0; i < 200; i++)
            cyc(-9000, -4000, 0, 1, 3000, 6, 1, "R2");

        // R3: no strobe, phases and threshold wander, accumulator must hold
        for (int i = 0; i < 300; i++)
            cyc($urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
                $urandom_range(0, 65535) - 32768, 0,
                $urandom_range(0, 9000), $urandom_range(0, 15), 1, "R3");

        // R2: random mix with back-to-back strobes
        for (int i = 0; i < 6000; i++) begin
            int a = $urandom_range(0, 65535) - 32768;
            int b = $urandom_range(0, 65535) - 32768;
            int c = ($urandom_range(0, 3) == 0) ? ($urandom_range(0, 65535) - 32768) : (-a - b) / 2;
            cyc(a, b, c, $urandom_range(0, 3) != 0, $urandom_range(0, 12000),
                $urandom_range(0, 15), $urandom_range(0, 9) != 0, "R2");
        end

        cyc(0, 0, 0, 0, 1, 0, 1, "R4");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule